// File: doc/BRIEF.md
# Three-Sample Block FIR Filter

This block is a three-tap finite impulse response filter, y(n) = h0·x(n) + h1·x(n-1) + h2·x(n-2), that has been recast to work on whole blocks of samples. On every clock where the input is marked valid, it takes three consecutive samples side by side. The bus carries x(3k) in lane 0, x(3k+1) in lane 1 and x(3k+2) in lane 2. One cycle later it presents the three matching outputs in the same lane order. Because three samples are consumed per cycle, the clock may run at one third of the sample rate.

Each output lane evaluates its own copy of the convolution in parallel with the others. The taps that reach back before the current block are lanes 1 and 2 of the previous valid block. These are held in a one-block history register. The coefficients are static signed inputs. Products are kept at full precision and summed, and only the final sum is cut down to the output width.

Top module: `blk3_fir`

## Requirements
- R1: While `rst` is high at a clock edge, `out_vld` goes to 0, all three outputs go to 0 and the history register is cleared.
- R2: `out_vld` equals the value `in_vld` had at the previous clock edge, a latency of exactly one cycle.
- R3: After a valid block, `out_y2` = h0·x(3k+2) + h1·x(3k+1) + h2·x(3k), which uses only current-block samples (lane 2 = x(3k+2), lane 1 = x(3k+1), lane 0 = x(3k)).
- R4: After a valid block, `out_y1` = h0·x(3k+1) + h1·x(3k) + h2·x(3k-1), where x(3k-1) is lane 2 of the previous valid block.
- R5: After a valid block, `out_y0` = h0·x(3k) + h1·x(3k-1) + h2·x(3k-2), where x(3k-1) is lane 2 and x(3k-2) is lane 1 of the previous valid block.
- R6: A cycle with `in_vld` low changes neither the three outputs nor the history, whatever the sample lanes carry.
- R7: The first valid block after reset treats all earlier samples as zero, so `out_y0` = h0·x(3k) and `out_y1` = h0·x(3k+1) + h1·x(3k).
- R8: Samples and coefficients are two's complement. Each output is the low OW bits of the exact sum of full-precision products, and it wraps when the sum does not fit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Input block valid |
| in_s0 | input | DW | Sample x(3k), signed |
| in_s1 | input | DW | Sample x(3k+1), signed |
| in_s2 | input | DW | Sample x(3k+2), signed |
| coef0 | input | CW | Coefficient h0, signed |
| coef1 | input | CW | Coefficient h1, signed |
| coef2 | input | CW | Coefficient h2, signed |
| out_vld | output | 1 | Output block valid |
| out_y0 | output | OW | Output y(3k), signed |
| out_y1 | output | OW | Output y(3k+1), signed |
| out_y2 | output | OW | Output y(3k+2), signed |

## Verification
The bench sweeps every coefficient triple of a 4-bit configuration with an 8-bit output, so the exact sum sometimes overflows. A design that dropped sign extension or truncated the wrong end would show up as wrong wrapped values. It places idle cycles carrying junk samples between valid blocks. A history register that loaded on every clock would then corrupt `out_y0` and `out_y1` of the next block, and outputs that followed the junk would change during idle cycles. Reset is pulsed mid-stream and followed directly by a block. Leftover history would leak into the cross terms, and a swapped history pair would give wrong values for lanes 0 and 1 only.

// File: rtl/blk3_fir_pkg.sv
package blk3_fir_pkg;
  localparam int LANES = 3;
  localparam int TAPS  = 3;
  localparam int WIN   = LANES + TAPS - 1;
endpackage

// File: rtl/blk3_fir_hist.sv
module blk3_fir_hist #(
  parameter int DW = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic signed [DW-1:0] cur_mid,
  input  logic signed [DW-1:0] cur_last,
  output logic signed [DW-1:0] old_mid,
  output logic signed [DW-1:0] old_last
);
  always_ff @(posedge clk) begin
    if (rst) begin
      old_mid  <= '0;
      old_last <= '0;
    end else if (en) begin
      old_mid  <= cur_mid;
      old_last <= cur_last;
    end
  end
endmodule

// File: rtl/blk3_fir_lane.sv
module blk3_fir_lane #(
  parameter int DW = 8,
  parameter int CW = 8,
  parameter int OW = 18
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic signed [CW-1:0] h0,
  input  logic signed [CW-1:0] h1,
  input  logic signed [CW-1:0] h2,
  input  logic signed [DW-1:0] x_now,
  input  logic signed [DW-1:0] x_m1,
  input  logic signed [DW-1:0] x_m2,
  output logic signed [OW-1:0] y
);
  localparam int PW = DW + CW;
  localparam int SW = PW + 2;
  localparam int XW = (OW > SW) ? OW : SW;

  logic signed [PW-1:0] m0, m1, m2;
  logic signed [XW-1:0] acc;

  always_comb begin
    m0  = x_now * h0;
    m1  = x_m1 * h1;
    m2  = x_m2 * h2;
    acc = XW'(m0) + XW'(m1) + XW'(m2);
  end

  always_ff @(posedge clk) begin
    if (rst) y <= '0;
    else if (en) y <= acc[OW-1:0];
  end
endmodule

// File: rtl/blk3_fir.sv
module blk3_fir
  import blk3_fir_pkg::*;
#(
  parameter int DW = 8,
  parameter int CW = 8,
  parameter int OW = 18
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_vld,
  input  logic signed [DW-1:0] in_s0,
  input  logic signed [DW-1:0] in_s1,
  input  logic signed [DW-1:0] in_s2,
  input  logic signed [CW-1:0] coef0,
  input  logic signed [CW-1:0] coef1,
  input  logic signed [CW-1:0] coef2,
  output logic                 out_vld,
  output logic signed [OW-1:0] out_y0,
  output logic signed [OW-1:0] out_y1,
  output logic signed [OW-1:0] out_y2
);
  logic signed [DW-1:0] prev1, prev2;
  logic signed [DW-1:0] win [WIN];
  logic signed [OW-1:0] ly  [LANES];

  blk3_fir_hist #(.DW(DW)) u_hist (
    .clk(clk), .rst(rst), .en(in_vld),
    .cur_mid(in_s1), .cur_last(in_s2),
    .old_mid(prev1), .old_last(prev2)
  );

  // window: oldest first, x(3k-2) .. x(3k+2)
  always_comb begin
    win[0] = prev1;
    win[1] = prev2;
    win[2] = in_s0;
    win[3] = in_s1;
    win[4] = in_s2;
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    blk3_fir_lane #(.DW(DW), .CW(CW), .OW(OW)) u_lane (
      .clk(clk), .rst(rst), .en(in_vld),
      .h0(coef0), .h1(coef1), .h2(coef2),
      .x_now(win[i+2]), .x_m1(win[i+1]), .x_m2(win[i]),
      .y(ly[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) out_vld <= 1'b0;
    else     out_vld <= in_vld;
  end

  assign out_y0 = ly[0];
  assign out_y1 = ly[1];
  assign out_y2 = ly[2];
endmodule

// File: rtl/blk3_fir_chk.sv
module blk3_fir_chk #(
  parameter int DW = 8,
  parameter int CW = 8,
  parameter int OW = 18
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 in_vld,
  input logic signed [DW-1:0] in_s0,
  input logic signed [DW-1:0] in_s1,
  input logic signed [DW-1:0] in_s2,
  input logic signed [CW-1:0] coef0,
  input logic signed [CW-1:0] coef1,
  input logic signed [CW-1:0] coef2,
  input logic                 out_vld,
  input logic signed [OW-1:0] out_y0,
  input logic signed [OW-1:0] out_y1,
  input logic signed [OW-1:0] out_y2
);
  localparam int XW = ((DW + CW + 2) > OW) ? (DW + CW + 2) : OW;

  logic signed [XW-1:0] ref2;
  logic signed [OW-1:0] ref2_t;
  always_comb begin
    ref2   = XW'(in_s2) * XW'(coef0) + XW'(in_s1) * XW'(coef1) + XW'(in_s0) * XW'(coef2);
    ref2_t = ref2[OW-1:0];
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (!out_vld && out_y0 == '0 && out_y1 == '0 && out_y2 == '0));

  assert_vld_follow_R2: assert property (@(posedge clk) disable iff (rst)
    in_vld |=> out_vld);

  assert_vld_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !in_vld |=> !out_vld);

  assert_last_lane_R3: assert property (@(posedge clk) disable iff (rst)
    in_vld |=> out_y2 == $past(ref2_t));

  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !in_vld |=> ($stable(out_y0) && $stable(out_y1) && $stable(out_y2)));
endmodule

bind blk3_fir blk3_fir_chk #(.DW(DW), .CW(CW), .OW(OW)) u_chk (
  .clk(clk), .rst(rst), .in_vld(in_vld),
  .in_s0(in_s0), .in_s1(in_s1), .in_s2(in_s2),
  .coef0(coef0), .coef1(coef1), .coef2(coef2),
  .out_vld(out_vld), .out_y0(out_y0), .out_y1(out_y1), .out_y2(out_y2)
);

// File: tb/sim_blk3_fir.sv
`timescale 1ns/1ps
module sim_blk3_fir;
  localparam int DW = 4;
  localparam int CW = 4;
  localparam int OW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_vld = 1'b0;
  logic signed [DW-1:0] in_s0 = '0, in_s1 = '0, in_s2 = '0;
  logic signed [CW-1:0] coef0 = '0, coef1 = '0, coef2 = '0;
  logic out_vld;
  logic signed [OW-1:0] out_y0, out_y1, out_y2;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  int mp1 = 0, mp2 = 0;
  int h0 = 0, h1 = 0, h2 = 0;
  int last0 = 0, last1 = 0, last2 = 0;

  always #2.5 clk = ~clk;

  blk3_fir #(.DW(DW), .CW(CW), .OW(OW)) u0 (
    .clk(clk), .rst(rst), .in_vld(in_vld),
    .in_s0(in_s0), .in_s1(in_s1), .in_s2(in_s2),
    .coef0(coef0), .coef1(coef1), .coef2(coef2),
    .out_vld(out_vld), .out_y0(out_y0), .out_y1(out_y1), .out_y2(out_y2)
  );

  function automatic int tr(input int s);
    logic signed [OW-1:0] t;
    t = s[OW-1:0];
    return int'(t);
  endfunction

  function automatic int sg4(input int v);
    return (v >= 8) ? v - 16 : v;
  endfunction

  function automatic string tg(input int s, input string base);
    return (s > 127 || s < -128) ? {base, "/R8"} : base;
  endfunction

  task automatic chk(input int got, input int exp, input string tag);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
    end
  endtask

  task automatic blk(input bit v, input int a, input int b, input int c);
    int s0, s1, s2;
    @(negedge clk);
    in_vld = v;
    in_s0 = a[DW-1:0]; in_s1 = b[DW-1:0]; in_s2 = c[DW-1:0];
    @(posedge clk); #1;
    if (v) begin
      s0 = h0*a + h1*mp2 + h2*mp1;
      s1 = h0*b + h1*a + h2*mp2;
      s2 = h0*c + h1*b + h2*a;
      chk(int'(out_vld), 1, "R2");
      chk(int'(out_y0), tr(s0), tg(s0, "R5"));
      chk(int'(out_y1), tr(s1), tg(s1, "R4"));
      chk(int'(out_y2), tr(s2), tg(s2, "R3"));
      last0 = tr(s0); last1 = tr(s1); last2 = tr(s2);
      mp1 = b; mp2 = c;
    end else begin
      chk(int'(out_vld), 0, "R2");
      chk(int'(out_y0), last0, "R6");
      chk(int'(out_y1), last1, "R6");
      chk(int'(out_y2), last2, "R6");
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_vld = 1'b1;
    in_s0 = 4'sd7; in_s1 = -4'sd8; in_s2 = 4'sd5;
    @(posedge clk); @(posedge clk); #1;
    chk(int'(out_vld), 0, "R1");
    chk(int'(out_y0), 0, "R1");
    chk(int'(out_y1), 0, "R1");
    chk(int'(out_y2), 0, "R1");
    @(negedge clk);
    rst = 1'b0; in_vld = 1'b0;
    mp1 = 0; mp2 = 0; last0 = 0; last1 = 0; last2 = 0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired got=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R7: first block after reset sees zero history
    h0 = -3; h1 = 5; h2 = 7;
    coef0 = 4'(h0); coef1 = 4'(h1); coef2 = 4'(h2);
    blk(1'b1, 6, -4, 2);
    chk(int'(out_y0), tr(-3*6), "R7");
    chk(int'(out_y1), tr(-3*-4 + 5*6), "R7");

    for (int idx = 0; idx < 4096; idx++) begin
      h0 = sg4(idx & 15); h1 = sg4((idx >> 4) & 15); h2 = sg4((idx >> 8) & 15);
      @(negedge clk);
      coef0 = 4'(h0); coef1 = 4'(h1); coef2 = 4'(h2);
      if ((idx % 1024) == 1000) begin
        do_reset();
        blk(1'b1, -8, -8, -8);
        chk(int'(out_y0), tr(h0 * -8), "R7");
      end
      blk(1'b1, sg4((idx + 3) & 15), sg4((idx * 7 + 1) & 15), sg4((idx * 5 + 9) & 15));
      if ((idx % 4) == 2) blk(1'b0, sg4((idx * 3) & 15), -8, 7);
      blk(1'b1, sg4((idx * 11 + 4) & 15), sg4((idx + 8) & 15), sg4((idx * 13) & 15));
    end

    // extreme operands: largest positive and negative sums wrap
    h0 = -8; h1 = -8; h2 = -8;
    @(negedge clk);
    coef0 = 4'(h0); coef1 = 4'(h1); coef2 = 4'(h2);
    blk(1'b1, -8, -8, -8);
    blk(1'b1, -8, -8, -8);
    blk(1'b1, 7, 7, 7);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule